// File: doc/BRIEF.md
# Gated Edge Counter with Acquisition Window

This block measures the frequency of a digital input by counting its rising edges during a fixed stretch of reference clock cycles. Software, or a controlling block, arms it with a sample control bit. While that bit is low, the result register shows all ones. When the bit goes high, the register drops to zero and counts input edges for one acquisition window. The register then freezes, so that a serial readout path can shift the value out at its own pace. A width select chooses between a short and a long window. The choice is taken when the count starts.

Two outside conditions can refuse or cancel a measurement. If a neighbouring converter reports that it is busy when the count would start, the start is refused. A standby request cancels a count that is running. In both cases the register stays at its all-ones idle value until the sample bit has been dropped and raised again. The input is assumed to be already synchronous to the reference clock. A done flag tells the reader when the held value is final.

Top module: `edge_window_counter`

## Requirements
- R1: During and directly after reset, `count_q` is all ones and `done` is 0.
- R2: While `sample_en` is low, the cycle after it is sampled low shows `count_q` all ones and `done` at 0.
- R3: When `sample_en` is first sampled high and neither `conv_busy` nor `standby` is high, `count_q` reads 0 on the next cycle. After that, each clock at which `sig_in` is 1 and was 0 at the previous clock adds one. A rise at the starting clock itself is not counted.
- R4: The window covers the 2^NARROW_LOG2 clocks after the start when `wide_sel` was 0 at the start, or 2^WIDE_LOG2 clocks when it was 1. `done` reads 1 exactly that many cycles after `count_q` first read 0, and it reads 0 one cycle before that.
- R5: After the window, `count_q` stays frozen and `done` stays 1 for as long as `sample_en` is held high, whatever `sig_in` does. Nothing but `sample_en` falling ends the hold.
- R6: If the count reaches all ones inside the window, it stays at all ones and does not wrap.
- R7: If `conv_busy` is high when `sample_en` is first sampled high, no count starts. `count_q` stays all ones and `done` stays 0 until `sample_en` falls, even if `conv_busy` drops meanwhile.
- R8: `standby` high at the start refuses the count. `standby` high during the window aborts the count: on the next cycle `count_q` is all ones and `done` is 0, and they stay that way until `sample_en` falls. This also holds when the abort falls on the window's last clock.
- R9: A change of `wide_sel` after the start does not change the length of the running window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_en | input | 1 | Arms a count while high; low presets the result to all ones |
| wide_sel | input | 1 | Window select taken at the start: 0 short, 1 long |
| conv_busy | input | 1 | Converter busy; refuses a start |
| standby | input | 1 | Refuses a start or aborts a running count |
| sig_in | input | 1 | Synchronous signal whose rising edges are counted |
| count_q | output | CNT_W | Edge count, preset or held value |
| done | output | 1 | High while a finished count is held |

## Verification
Two cases can fall on the same clock: the window's final clock and a standby abort. The bench raises `standby` so that it is sampled on exactly the clock where the window would close. It then expects the abort to win: all ones and `done` at 0, with no frozen count and no done pulse, and this state must last for a further full window. A second overlap is a rising edge on the last clock of the window. The period and phase sweep covers it, and the arithmetic expected count includes that final edge.

// File: rtl/ewc_pkg.sv
package ewc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_HOLD  = 2'd2,
    ST_BLOCK = 2'd3
  } ewc_state_t;
endpackage

// File: rtl/ewc_rise_detect.sv
module ewc_rise_detect (
  input  logic clk,
  input  logic rst,
  input  logic sig_in,
  output logic rise
);
  logic sig_d;

  always_ff @(posedge clk) begin
    if (rst) sig_d <= 1'b0;
    else     sig_d <= sig_in;
  end

  assign rise = sig_in & ~sig_d;
endmodule

// File: rtl/ewc_win_timer.sv
module ewc_win_timer #(
  parameter int NARROW_LOG2 = 19,
  parameter int WIDE_LOG2   = 21
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic wide_in,
  input  logic run,
  output logic last
);
  localparam int TW = (WIDE_LOG2 > NARROW_LOG2) ? WIDE_LOG2 : NARROW_LOG2;
  localparam logic [TW-1:0] NAR_LAST  = TW'((64'd1 << NARROW_LOG2) - 64'd1);
  localparam logic [TW-1:0] WIDE_LAST = TW'((64'd1 << WIDE_LOG2) - 64'd1);

  logic [TW-1:0] tmr;
  logic          wide_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr    <= '0;
      wide_q <= 1'b0;
    end else if (clear) begin
      tmr    <= '0;
      wide_q <= wide_in;
    end else if (run) begin
      tmr <= tmr + 1'b1;
    end
  end

  assign last = run && (tmr == (wide_q ? WIDE_LAST : NAR_LAST));
endmodule

// File: rtl/ewc_sat_counter.sv
module ewc_sat_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             preset,
  input  logic             zero,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)                           count <= ALL_ONES;
    else if (preset)                   count <= ALL_ONES;
    else if (zero)                     count <= '0;
    else if (inc && count != ALL_ONES) count <= count + 1'b1;
  end
endmodule

// File: rtl/ewc_ctrl.sv
module ewc_ctrl
  import ewc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sample_en,
  input  logic conv_busy,
  input  logic standby,
  input  logic win_last,
  input  logic rise,
  output logic tmr_clear,
  output logic tmr_run,
  output logic cnt_preset,
  output logic cnt_zero,
  output logic cnt_inc,
  output logic done_q
);
  ewc_state_t state, nxt;

  always_comb begin
    nxt        = state;
    tmr_clear  = 1'b0;
    tmr_run    = 1'b0;
    cnt_preset = 1'b0;
    cnt_zero   = 1'b0;
    cnt_inc    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (sample_en && !conv_busy && !standby) begin
          nxt       = ST_RUN;
          cnt_zero  = 1'b1;
          tmr_clear = 1'b1;
        end else begin
          cnt_preset = 1'b1;
          if (sample_en) nxt = ST_BLOCK;
        end
      end
      ST_RUN: begin
        tmr_run = 1'b1;
        if (!sample_en || standby) begin
          cnt_preset = 1'b1;
          nxt        = sample_en ? ST_BLOCK : ST_IDLE;
        end else begin
          cnt_inc = rise;
          if (win_last) nxt = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (!sample_en) begin
          cnt_preset = 1'b1;
          nxt        = ST_IDLE;
        end
      end
      default: begin
        cnt_preset = 1'b1;
        if (!sample_en) nxt = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      state  <= nxt;
      done_q <= (nxt == ST_HOLD);
    end
  end
endmodule

// File: rtl/edge_window_counter.sv
module edge_window_counter #(
  parameter int CNT_W       = 24,
  parameter int NARROW_LOG2 = 19,
  parameter int WIDE_LOG2   = 21
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sample_en,
  input  logic             wide_sel,
  input  logic             conv_busy,
  input  logic             standby,
  input  logic             sig_in,
  output logic [CNT_W-1:0] count_q,
  output logic             done
);
  logic rise, win_last, tmr_clear, tmr_run;
  logic cnt_preset, cnt_zero, cnt_inc;

  ewc_rise_detect u_rise (
    .clk    (clk),
    .rst    (rst),
    .sig_in (sig_in),
    .rise   (rise)
  );

  ewc_win_timer #(
    .NARROW_LOG2 (NARROW_LOG2),
    .WIDE_LOG2   (WIDE_LOG2)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .clear   (tmr_clear),
    .wide_in (wide_sel),
    .run     (tmr_run),
    .last    (win_last)
  );

  ewc_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .sample_en  (sample_en),
    .conv_busy  (conv_busy),
    .standby    (standby),
    .win_last   (win_last),
    .rise       (rise),
    .tmr_clear  (tmr_clear),
    .tmr_run    (tmr_run),
    .cnt_preset (cnt_preset),
    .cnt_zero   (cnt_zero),
    .cnt_inc    (cnt_inc),
    .done_q     (done)
  );

  ewc_sat_counter #(
    .CNT_W (CNT_W)
  ) u_count (
    .clk    (clk),
    .rst    (rst),
    .preset (cnt_preset),
    .zero   (cnt_zero),
    .inc    (cnt_inc),
    .count  (count_q)
  );
endmodule

// File: rtl/ewc_checker.sv
module ewc_checker #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             sample_en,
  input logic             conv_busy,
  input logic             standby,
  input logic [CNT_W-1:0] count_q,
  input logic             done
);
  localparam logic [CNT_W-1:0] ONES = {CNT_W{1'b1}};

  AST_PRESET_WHEN_LOW: assert property (@(posedge clk) disable iff (rst)
    !sample_en |=> (count_q == ONES && !done)); // R2

  AST_ROLL_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($rose(sample_en) && !conv_busy && !standby) |=> (count_q == '0)); // R3

  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (done && sample_en) |=> (done && $stable(count_q))); // R5

  AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (rst)
    ($rose(sample_en) && conv_busy) |=> (count_q == ONES && !done)); // R7

  AST_STANDBY_ABORT: assert property (@(posedge clk) disable iff (rst)
    (standby && sample_en && !done) |=> (count_q == ONES && !done)); // R8
endmodule

bind edge_window_counter ewc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sample_en (sample_en),
  .conv_busy (conv_busy),
  .standby   (standby),
  .count_q   (count_q),
  .done      (done)
);

// File: tb/edge_window_counter_tb.sv
`timescale 1ns/1ps
module edge_window_counter_tb;
  localparam int CW   = 5;
  localparam int NL   = 4;
  localparam int WL   = 6;
  localparam int NN   = 1 << NL;
  localparam int NW   = 1 << WL;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sample_en = 1'b0, wide_sel = 1'b0, conv_busy = 1'b0;
  logic standby = 1'b0, sig_in = 1'b0;
  logic [CW-1:0] count_q;
  logic done;
  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  edge_window_counter #(.CNT_W(CW), .NARROW_LOG2(NL), .WIDE_LOG2(WL)) u_dut (
    .clk(clk), .rst(rst), .sample_en(sample_en), .wide_sel(wide_sel),
    .conv_busy(conv_busy), .standby(standby), .sig_in(sig_in),
    .count_q(count_q), .done(done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic sig_at(input int i, input int p, input int ph);
    if (p == 1) return 1'b1;
    return ((i + ph) % p) == 0;
  endfunction

  task automatic run_window(input bit wide, input int p, input int ph,
                            input int abort_at, input bit flip, input int hold_extra);
    int n;
    int exp;
    n = wide ? NW : NN;
    exp = 0;
    if (p > 1) for (int i = 1; i <= n; i++) if (((i + ph) % p) == 0) exp++;
    if (exp > MAXC) exp = MAXC;
    @(negedge clk);
    sample_en = 1'b1; wide_sel = wide; sig_in = sig_at(0, p, ph);
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (i == 1) chk("R3 rollover to zero", int'(count_q), 0);
      if (i == n) chk("R4 done low one cycle early", int'(done), 0);
      if (flip && i == 3) wide_sel = ~wide;
      if (abort_at == i) standby = 1'b1;
      sig_in = sig_at(i, p, ph);
    end
    @(negedge clk);
    if (abort_at != 0) begin
      chk("R8 abort count preset", int'(count_q), MAXC);
      chk("R8 abort done low", int'(done), 0);
      repeat (n) @(negedge clk);
      chk("R8 abort persists count", int'(count_q), MAXC);
      chk("R8 abort persists done", int'(done), 0);
    end else begin
      chk(exp == MAXC ? "R6 saturated count" : "R3 edge count", int'(count_q), exp);
      chk(flip ? "R9 window kept" : "R4 done at window end", int'(done), 1);
      for (int k = 0; k < hold_extra; k++) begin
        sig_in = ~sig_in;
        @(negedge clk);
      end
      if (hold_extra > 0) begin
        chk("R5 held count", int'(count_q), exp);
        chk("R5 held done", int'(done), 1);
      end
    end
    sample_en = 1'b0; standby = 1'b0; sig_in = 1'b0;
    @(negedge clk);
    chk("R2 preset count", int'(count_q), MAXC);
    chk("R2 preset done", int'(done), 0);
  endtask

  task automatic refused_start(input bit use_busy);
    @(negedge clk);
    if (use_busy) conv_busy = 1'b1; else standby = 1'b1;
    sample_en = 1'b1;
    repeat (NN + 4) begin
      sig_in = ~sig_in;
      @(negedge clk);
    end
    chk(use_busy ? "R7 busy refuses count" : "R8 standby refuses count", int'(count_q), MAXC);
    chk(use_busy ? "R7 busy refuses done" : "R8 standby refuses done", int'(done), 0);
    conv_busy = 1'b0; standby = 1'b0;
    repeat (NN + 4) begin
      sig_in = ~sig_in;
      @(negedge clk);
    end
    chk(use_busy ? "R7 still refused count" : "R8 still refused count", int'(count_q), MAXC);
    chk(use_busy ? "R7 still refused done" : "R8 still refused done", int'(done), 0);
    sample_en = 1'b0; sig_in = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset count", int'(count_q), MAXC);
    chk("R1 reset done", int'(done), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset count", int'(count_q), MAXC);
    for (int w = 0; w < 2; w++) begin
      for (int p = 1; p <= 7; p++) begin
        if (p == 6) continue;
        for (int ph = 0; ph < p; ph++) run_window(w[0], p, ph, 0, 1'b0, 0);
      end
    end
    run_window(1'b0, 3, 1, 0, 1'b0, 25);
    run_window(1'b1, 4, 2, 0, 1'b0, 40);
    refused_start(1'b1);
    run_window(1'b0, 2, 0, 0, 1'b0, 0);
    refused_start(1'b0);
    run_window(1'b0, 3, 0, 7, 1'b0, 0);
    run_window(1'b0, 3, 0, NN, 1'b0, 0);
    run_window(1'b1, 5, 0, NW, 1'b0, 0);
    run_window(1'b0, 4, 1, 0, 1'b1, 0);
    run_window(1'b1, 4, 1, 0, 1'b1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule